// File: doc/BRIEF.md
# Sync and Video-Activity Timing Analyzer

This block watches the four timing signals of an incoming display raster (horizontal sync, horizontal flyback, vertical sync and the video-active indication) and turns them into a bank of 12-bit timing figures. Firmware uses these figures to set up picture size and centring on its own. The block runs on a fine time-base clock, and one clock period is the unit for every horizontal-type figure. The high and low phases of horizontal sync, flyback and video-active are measured in clock periods. The high and low phases of vertical sync are measured in lines, which means the number of horizontal sync leading edges seen while the level is held. The block also records where video activity starts and ends within a line, as offsets from the horizontal sync leading edge.

Each input passes through its own multi-flop synchroniser. A shared trigger event, raised once per frame on a chosen line, closes the current measurement window. On that event the finished figures are copied into an output bank, which then holds steady until the next trigger, so the reader always sees one coherent set. The same event also restarts every counter. All counters clamp at their all-ones value. A flag for each figure marks results that fall outside the usable range of 2 to 4091, and it also marks figures that were never captured in the window.

Top module: `sync_timing_analyzer`

## Requirements
- R1: After reset, `meas_valid_o` is 0, every slot of `meas_o` is 0 and every bit of `meas_oor_o` is 1.
- R2: For horizontal-type inputs, a completed high (or low) phase lasting N clock cycles is reported as N. Slots are 0/1 for horizontal sync high/low, 2/3 for flyback high/low and 4/5 for video-active high/low. When several phases complete in one window, the last one is reported.
- R3: Vertical sync high/low phases are reported in slots 6/7 as the count of horizontal sync rising edges that occur while the level is held.
- R4: Slot 8 gives the offset in clock cycles from the horizontal sync rising edge to the first video-active rising edge of the line.
- R5: Slot 9 gives the offset in clock cycles from the horizontal sync rising edge to the most recent video-active falling edge.
- R6: A one-cycle pulse on `trig_i` publishes the window's figures on the next cycle and sets `meas_valid_o`, which then stays 1. Without a trigger, the bank and the flags do not change, whatever the inputs do.
- R7: A trigger restarts the measurement. The first edge of each signal after a trigger only starts timing. A phase that began before the trigger is not reported, and a slot with nothing captured in the window publishes 0 with its flag set.
- R8: A slot's flag is 1 exactly when its published value is below 2 or above 4091. The values 2 and 4091 are in range.
- R9: Counters saturate, so a phase of 4095 cycles or longer is reported as 4095.
- R10: A second video-active rising edge within the same line does not change slot 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fine time-base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_i | input | 1 | Vertical sync, active high, asynchronous |
| hfly_i | input | 1 | Horizontal flyback, active high, asynchronous |
| vact_i | input | 1 | Video-active indication, active high, asynchronous |
| trig_i | input | 1 | Window-closing trigger pulse, synchronous |
| meas_o | output | 10x12 | Published measurement bank, slot order as in R2 to R5 |
| meas_oor_o | output | 10 | Out-of-range flag for each slot |
| meas_valid_o | output | 1 | High once the first window has been published |

## Verification
The bench builds the block with its default parameters: 12-bit counters, a usable range of 2 to 4091 and two synchroniser stages. With these widths, the clamp and the range edges are only a few thousand cycles away. Phases of exactly 2, 4091 and 4092 cycles and a phase that runs past 4095 are driven at their real values, with no scaled-down stand-ins. Vertical sync is driven over a few short synthetic lines, so line counting and activity-edge offsets are checked in full.

// File: rtl/vta_pkg.sv
package vta_pkg;
    localparam int VTA_CNT_W       = 12;
    localparam int VTA_MIN_OK      = 2;
    localparam int VTA_MAX_OK      = 4091;
    localparam int VTA_SYNC_STAGES = 2;
    localparam int VTA_NUM_IN      = 4;
    localparam int VTA_NUM_H       = 3;
    localparam int VTA_NUM_MEAS    = 2 * VTA_NUM_H + 4;
    localparam int SLOT_VS_HI      = 2 * VTA_NUM_H;
    localparam int SLOT_VS_LO      = 2 * VTA_NUM_H + 1;
    localparam int SLOT_ACT_FIRST  = 2 * VTA_NUM_H + 2;
    localparam int SLOT_ACT_LAST   = 2 * VTA_NUM_H + 3;
endpackage

// File: rtl/vta_sync.sv
module vta_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_s;

    sync_s sync_d, sync_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("vta_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        sync_d.chain = {sync_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.chain[STAGES-1];
endmodule

// File: rtl/vta_width_meter.sv
module vta_width_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lvl_i,
    input  logic             step_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o,
    output logic             hi_seen_o,
    output logic             lo_seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic             hi_seen;
        logic             lo_seen;
    } meter_s;

    meter_s mtr_d, mtr_q;
    logic             lvl_change;
    logic [CNT_W-1:0] step_ext;

    always_comb begin
        mtr_d      = mtr_q;
        step_ext   = {{(CNT_W-1){1'b0}}, step_i};
        lvl_change = lvl_i ^ mtr_q.prev;
        mtr_d.prev = lvl_i;
        if (clr_i) begin
            // window restart: forget partial phase, wait for a fresh edge
            mtr_d.armed   = 1'b0;
            mtr_d.run     = '0;
            mtr_d.hi      = '0;
            mtr_d.lo      = '0;
            mtr_d.hi_seen = 1'b0;
            mtr_d.lo_seen = 1'b0;
        end else if (lvl_change) begin
            if (mtr_q.armed) begin
                if (mtr_q.prev) begin
                    mtr_d.hi      = mtr_q.run;
                    mtr_d.hi_seen = 1'b1;
                end else begin
                    mtr_d.lo      = mtr_q.run;
                    mtr_d.lo_seen = 1'b1;
                end
            end
            mtr_d.armed = 1'b1;
            mtr_d.run   = step_ext;
        end else if (mtr_q.run != CNT_MAX) begin
            mtr_d.run = mtr_q.run + step_ext;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mtr_q <= '0;
        end else begin
            mtr_q <= mtr_d;
        end
    end

    assign hi_o      = mtr_q.hi;
    assign lo_o      = mtr_q.lo;
    assign hi_seen_o = mtr_q.hi_seen;
    assign lo_seen_o = mtr_q.lo_seen;
endmodule

// File: rtl/vta_edge_pos.sv
module vta_edge_pos #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_start_i,
    input  logic             act_rise_i,
    input  logic             act_fall_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] first_o,
    output logic [CNT_W-1:0] last_o,
    output logic             first_seen_o,
    output logic             last_seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             line_ok;
        logic             got_first;
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] last;
        logic             first_seen;
        logic             last_seen;
    } pos_s;

    pos_s pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (line_start_i) begin
            pos_d.pos = CNT_ONE;
        end else if (pos_q.pos != CNT_MAX) begin
            pos_d.pos = pos_q.pos + CNT_ONE;
        end

        if (clr_i) begin
            pos_d.line_ok    = 1'b0;
            pos_d.got_first  = 1'b0;
            pos_d.first      = '0;
            pos_d.last       = '0;
            pos_d.first_seen = 1'b0;
            pos_d.last_seen  = 1'b0;
        end else begin
            if (pos_q.line_ok) begin
                if (act_rise_i && !pos_q.got_first) begin
                    pos_d.first      = pos_q.pos;
                    pos_d.got_first  = 1'b1;
                    pos_d.first_seen = 1'b1;
                end
                if (act_fall_i) begin
                    pos_d.last      = pos_q.pos;
                    pos_d.last_seen = 1'b1;
                end
            end
            if (line_start_i) begin
                pos_d.line_ok   = 1'b1;
                pos_d.got_first = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign first_o      = pos_q.first;
    assign last_o       = pos_q.last;
    assign first_seen_o = pos_q.first_seen;
    assign last_seen_o  = pos_q.last_seen;
endmodule

// File: rtl/sync_timing_analyzer.sv
module sync_timing_analyzer
    import vta_pkg::*;
#(
    parameter int CNT_W       = VTA_CNT_W,
    parameter int MIN_OK      = VTA_MIN_OK,
    parameter int MAX_OK      = VTA_MAX_OK,
    parameter int SYNC_STAGES = VTA_SYNC_STAGES
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                hsync_i,
    input  logic                                vsync_i,
    input  logic                                hfly_i,
    input  logic                                vact_i,
    input  logic                                trig_i,
    output logic [VTA_NUM_MEAS-1:0][CNT_W-1:0] meas_o,
    output logic [VTA_NUM_MEAS-1:0]            meas_oor_o,
    output logic                                meas_valid_o
);
    localparam int               NUM   = VTA_NUM_MEAS;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_OK);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_OK);

    typedef struct packed {
        logic                      prev_hs;
        logic                      prev_act;
        logic [NUM-1:0][CNT_W-1:0] bank;
        logic [NUM-1:0]            oor;
        logic                      valid;
    } top_s;

    top_s top_d, top_q;

    logic [VTA_NUM_IN-1:0]     sync_w;
    logic                      s_hs, s_vs, s_fly, s_act;
    logic [VTA_NUM_H-1:0]      hsig;
    logic                      hs_rise, act_rise, act_fall;
    logic [NUM-1:0][CNT_W-1:0] work_val;
    logic [NUM-1:0]            work_seen;

    vta_sync #(
        .WIDTH  (VTA_NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({vact_i, hfly_i, vsync_i, hsync_i}),
        .sync_o  (sync_w)
    );

    assign s_hs  = sync_w[0];
    assign s_vs  = sync_w[1];
    assign s_fly = sync_w[2];
    assign s_act = sync_w[3];
    assign hsig  = {s_act, s_fly, s_hs};

    assign hs_rise  = s_hs & ~top_q.prev_hs;
    assign act_rise = s_act & ~top_q.prev_act;
    assign act_fall = ~s_act & top_q.prev_act;

    // one clock-unit width meter per horizontal-type input
    generate
        for (genvar g = 0; g < VTA_NUM_H; g++) begin : g_hmeter
            vta_width_meter #(
                .CNT_W (CNT_W)
            ) u_meter (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .lvl_i     (hsig[g]),
                .step_i    (1'b1),
                .clr_i     (trig_i),
                .hi_o      (work_val[2*g]),
                .lo_o      (work_val[2*g+1]),
                .hi_seen_o (work_seen[2*g]),
                .lo_seen_o (work_seen[2*g+1])
            );
        end
    endgenerate

    // vertical sync counts line starts instead of clocks
    vta_width_meter #(
        .CNT_W (CNT_W)
    ) u_vmeter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (s_vs),
        .step_i    (hs_rise),
        .clr_i     (trig_i),
        .hi_o      (work_val[SLOT_VS_HI]),
        .lo_o      (work_val[SLOT_VS_LO]),
        .hi_seen_o (work_seen[SLOT_VS_HI]),
        .lo_seen_o (work_seen[SLOT_VS_LO])
    );

    vta_edge_pos #(
        .CNT_W (CNT_W)
    ) u_pos (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .line_start_i (hs_rise),
        .act_rise_i   (act_rise),
        .act_fall_i   (act_fall),
        .clr_i        (trig_i),
        .first_o      (work_val[SLOT_ACT_FIRST]),
        .last_o       (work_val[SLOT_ACT_LAST]),
        .first_seen_o (work_seen[SLOT_ACT_FIRST]),
        .last_seen_o  (work_seen[SLOT_ACT_LAST])
    );

    always_comb begin
        top_d          = top_q;
        top_d.prev_hs  = s_hs;
        top_d.prev_act = s_act;
        if (trig_i) begin
            for (int i = 0; i < NUM; i++) begin
                top_d.bank[i] = work_seen[i] ? work_val[i] : '0;
                top_d.oor[i]  = !work_seen[i] || (work_val[i] < MIN_C)
                                || (work_val[i] > MAX_C);
            end
            top_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q.prev_hs  <= 1'b0;
            top_q.prev_act <= 1'b0;
            top_q.bank     <= '0;
            top_q.oor      <= '1;
            top_q.valid    <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign meas_o       = top_q.bank;
    assign meas_oor_o   = top_q.oor;
    assign meas_valid_o = top_q.valid;
endmodule

// File: rtl/vta_checker.sv
module vta_checker #(
    parameter int CNT_W  = 12,
    parameter int NUM    = 10,
    parameter int MIN_OK = 2,
    parameter int MAX_OK = 4091
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      trig_i,
    input logic [NUM-1:0][CNT_W-1:0] meas_o,
    input logic [NUM-1:0]            meas_oor_o,
    input logic                      meas_valid_o
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_OK);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_OK);

    // R6
    publish_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> meas_valid_o);

    // R6
    valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        meas_valid_o |=> meas_valid_o);

    // R6
    valid_from_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(meas_valid_o) |-> $past(trig_i));

    // R6
    bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_i |=> ($stable(meas_o) && $stable(meas_oor_o)));

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_slot
            // R8
            oor_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                meas_valid_o |-> (meas_oor_o[i] ==
                    ((meas_o[i] < MIN_C) || (meas_o[i] > MAX_C))));
        end
    endgenerate
endmodule

bind sync_timing_analyzer vta_checker #(
    .CNT_W  (CNT_W),
    .NUM    (vta_pkg::VTA_NUM_MEAS),
    .MIN_OK (MIN_OK),
    .MAX_OK (MAX_OK)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .meas_o       (meas_o),
    .meas_oor_o   (meas_oor_o),
    .meas_valid_o (meas_valid_o)
);

// File: tb/sync_timing_analyzer_tb.sv
module sync_timing_analyzer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0, vs = 1'b0, hf = 1'b0, av = 1'b0, trig = 1'b0;
    logic [9:0][11:0] meas;
    logic [9:0]       oor;
    logic             valid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_timing_analyzer dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hsync_i      (hs),
        .vsync_i      (vs),
        .hfly_i       (hf),
        .vact_i       (av),
        .trig_i       (trig),
        .meas_o       (meas),
        .meas_oor_o   (oor),
        .meas_valid_o (valid)
    );

    typedef struct packed {
        int chan;
        int hi;
        int lo;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{0, 5, 7},
        '{1, 2, 4091},
        '{2, 1, 3},
        '{0, 4092, 2},
        '{1, 4100, 9},
        '{2, 40, 60}
    };

    function automatic int clampv(input int v);
        return (v > 4095) ? 4095 : v;
    endfunction

    function automatic int oorv(input int v);
        return ((v < 2) || (v > 4091)) ? 1 : 0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_h(input int ch, input logic v);
        case (ch)
            0:       hs = v;
            1:       hf = v;
            default: av = v;
        endcase
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        tick(1);
        trig = 1'b0;
    endtask

    task automatic hs_line();
        hs = 1'b1;
        tick(4);
        hs = 1'b0;
        tick(16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 valid", int'(valid), 0);
        for (int i = 0; i < 10; i++) begin
            check("R1 slot value", int'(meas[i]), 0);
            check("R1 slot flag", int'(oor[i]), 1);
        end

        // R2 R8 R9 width vectors on horizontal-type inputs
        for (int v = 0; v < NV; v++) begin
            tick(6);
            pulse_trig();
            tick(2);
            set_h(VECS[v].chan, 1'b1);
            tick(VECS[v].hi);
            set_h(VECS[v].chan, 1'b0);
            tick(VECS[v].lo);
            set_h(VECS[v].chan, 1'b1);
            tick(6);
            pulse_trig();
            tick(1);
            check("R2 high width", int'(meas[2*VECS[v].chan]), clampv(VECS[v].hi));
            check("R2 low width", int'(meas[2*VECS[v].chan+1]), clampv(VECS[v].lo));
            check("R8 high flag", int'(oor[2*VECS[v].chan]), oorv(clampv(VECS[v].hi)));
            check("R8 low flag", int'(oor[2*VECS[v].chan+1]), oorv(clampv(VECS[v].lo)));
            check("R6 valid", int'(valid), 1);
            if (v == 0) begin
                // R7 untouched vertical slot publishes 0 with flag set
                check("R7 empty slot value", int'(meas[6]), 0);
                check("R7 empty slot flag", int'(oor[6]), 1);
            end
            set_h(VECS[v].chan, 1'b0);
        end
        // R9 explicit saturation figure from the 4100-cycle phase
        check("R9 clamp", clampv(4100), 4095);

        // R7 phase straddling a trigger is not reported
        tick(6);
        pulse_trig();
        tick(2);
        hf = 1'b1;
        tick(5);
        pulse_trig();
        tick(3);
        hf = 1'b0;
        tick(9);
        hf = 1'b1;
        tick(6);
        pulse_trig();
        tick(1);
        check("R7 straddled high value", int'(meas[2]), 0);
        check("R7 straddled high flag", int'(oor[2]), 1);
        check("R7 low after restart", int'(meas[3]), 9);
        hf = 1'b0;

        // R3 vertical sync in lines, plus R2 on the line pattern
        tick(6);
        pulse_trig();
        tick(2);
        hs_line();
        vs = 1'b1;
        tick(5);
        for (int k = 0; k < 3; k++) hs_line();
        vs = 1'b0;
        tick(5);
        for (int k = 0; k < 5; k++) hs_line();
        vs = 1'b1;
        tick(5);
        pulse_trig();
        tick(1);
        check("R3 vsync high lines", int'(meas[6]), 3);
        check("R3 vsync low lines", int'(meas[7]), 5);
        check("R2 hsync high", int'(meas[0]), 4);
        check("R2 hsync low", int'(meas[1]), 16);
        vs = 1'b0;

        // R4 R5 R10 activity edge offsets within one line
        tick(6);
        pulse_trig();
        tick(3);
        hs = 1'b1;
        tick(4);
        hs = 1'b0;
        tick(6);
        av = 1'b1;
        tick(15);
        av = 1'b0;
        tick(5);
        av = 1'b1;
        tick(10);
        av = 1'b0;
        tick(10);
        pulse_trig();
        tick(1);
        check("R4 R10 first activity offset", int'(meas[8]), 10);
        check("R5 last activity offset", int'(meas[9]), 40);
        check("R2 activity low", int'(meas[5]), 5);

        // R6 bank holds without a trigger
        for (int k = 0; k < 4; k++) begin
            hf = 1'b1;
            av = 1'b1;
            tick(3);
            hf = 1'b0;
            av = 1'b0;
            tick(3);
        end
        hs_line();
        tick(4);
        check("R6 hold first offset", int'(meas[8]), 10);
        check("R6 hold flyback high", int'(meas[2]), 0);
        check("R6 valid held", int'(valid), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule